// File: doc/BRIEF.md
# PRBS7 Word Generator and Checker

This block is the built-in self-test engine of a 10-bit word datapath. While the test enable is high, the transmit side drops the caller's parallel word. In its place it sends a seven-stage maximal-length pseudorandom pattern, ten pattern bits per word clock. The receive side takes the aligned 10-bit words that come back and synchronises a local copy of the same pattern from them. It then compares every following word against that copy and reports the result on a single pass flag.

A mode input selects how errors are shown. In live mode the pass flag shows the result of the most recent word. In latched mode the first error pulls the flag low, and it stays low until the test is stopped and started again. One word moves in each direction on every clock. The ports carry no handshake and no back-pressure: the datapath runs at a fixed word rate, and the bench and any user must supply a received word on every clock while the test runs.

Top module: `prbs7_bist`

## Requirements
- R1: The pattern uses the polynomial x^7 + x^6 + 1 with seed 7'h7F. Each step outputs state bit 6 and shifts in bit6 XOR bit5 at bit 0. Ten steps are taken per word. Word bit 0 holds the first bit in serial order and bit 9 the last. The word sequence therefore repeats every 127 words, and the generator state is never zero.
- R2: While `en_i` is high, `tx_word_o` carries the generated word and `tx_data_i` has no effect on it.
- R3: While `en_i` is low, `tx_word_o` equals `tx_data_i` and the generator returns to the seed. The first word after `en_i` rises is therefore the word generated from seed 7'h7F.
- R4: The checker seeds itself from the first two words captured after `en_i` rises. Bits 0..6 of the word become the next seven pattern bits. No error is reported for either of those words.
- R5: From the third captured word on, with `latch_i` low, `pass_o` is low after the clock edge that captures a word differing from the prediction. It is high after an edge that captures a matching word.
- R6: With `latch_i` high, a mismatching word drives `pass_o` low after its capturing edge. `pass_o` then stays low on later matching words for as long as `en_i` stays high.
- R7: A clock edge with `en_i` low clears any error state, so `pass_o` is high afterwards.
- R8: During and after reset (`rst_ni` low, active low, asynchronous), `pass_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Word clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Test enable for both generator and checker |
| latch_i | input | 1 | 1 = latched error reporting, 0 = live |
| tx_data_i | input | 10 | Caller's transmit word |
| rx_data_i | input | 10 | Received aligned word |
| tx_word_o | output | 10 | Transmit word, pattern while testing |
| pass_o | output | 1 | High when no error is reported |

## Verification
The hardest states to reach from the ports are an error that lands inside the seeding window and a sticky fail that has to outlast matching traffic. The bench loops the transmit word back into the receive port through an XOR mask it controls. It corrupts the very first seeding word completely, to show that the reseed on the second word recovers. Later it flips single bits at chosen words in both live and latched mode. A full 127-word loop after a restart confirms the pattern period and that the restart cleared the sticky fail.

// File: rtl/prbs7_pkg.sv
package prbs7_pkg;
  localparam int unsigned WORD_W = 10;
  localparam int unsigned LFSR_W = 7;
  localparam logic [LFSR_W-1:0] SEED = 7'h7F;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LFSR_W-1:0] lfsr_t;

  typedef struct packed {
    lfsr_t nxt;
    word_t bits;
  } step_t;

  // Advance the x^7+x^6+1 register one word; bit 0 is produced first.
  function automatic step_t prbs_run(input lfsr_t s);
    step_t r;
    lfsr_t t;
    t = s;
    r.bits = '0;
    for (int i = 0; i < WORD_W; i++) begin
      r.bits[i] = t[LFSR_W-1];
      t = {t[LFSR_W-2:0], t[LFSR_W-1] ^ t[LFSR_W-2]};
    end
    r.nxt = t;
    return r;
  endfunction

  // State whose next seven outputs equal word bits 0..6.
  function automatic lfsr_t seed_from(input word_t w);
    lfsr_t s;
    for (int i = 0; i < LFSR_W; i++) s[LFSR_W-1-i] = w[i];
    return s;
  endfunction
endpackage

// File: rtl/prbs7_gen.sv
module prbs7_gen
  import prbs7_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  word_t tx_data_i,
  output word_t tx_word_o
);
  lfsr_t state_q;
  step_t step;

  always_comb step = prbs_run(state_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    state_q <= SEED;
    else if (!en_i) state_q <= SEED;
    else            state_q <= step.nxt;
  end

  assign tx_word_o = en_i ? step.bits : tx_data_i;

  AST_GEN_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);  // R1
  AST_GEN_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> state_q == SEED);  // R3
endmodule

// File: rtl/prbs7_chk.sv
module prbs7_chk
  import prbs7_pkg::*;
#(
  parameter int unsigned SEED_WORDS = 2
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  logic  latch_i,
  input  word_t rx_data_i,
  output logic  pass_o
);
  localparam int unsigned PH_W = $clog2(SEED_WORDS + 1);
  localparam logic [PH_W-1:0] PH_RUN = PH_W'(SEED_WORDS);

  lfsr_t state_q;
  logic [PH_W-1:0] phase_q;
  logic err_q, sticky_q;
  step_t pred, reseed;
  logic miss;

  always_comb begin
    pred   = prbs_run(state_q);
    reseed = prbs_run(seed_from(rx_data_i));
    miss   = (rx_data_i != pred.bits);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= '0;
      phase_q  <= '0;
      err_q    <= 1'b0;
      sticky_q <= 1'b0;
    end else if (!en_i) begin
      state_q  <= '0;
      phase_q  <= '0;
      err_q    <= 1'b0;
      sticky_q <= 1'b0;
    end else if (phase_q != PH_RUN) begin
      state_q <= reseed.nxt;
      phase_q <= phase_q + 1'b1;
      err_q   <= 1'b0;
    end else begin
      state_q <= pred.nxt;
      err_q   <= miss;
      if (latch_i && miss) sticky_q <= 1'b1;
    end
  end

  assign pass_o = !(err_q || sticky_q);

  AST_SEED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && phase_q != PH_RUN) |=> pass_o || sticky_q);  // R4
  AST_STICKY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && sticky_q) |=> !pass_o);  // R6
  AST_OFF_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> pass_o);  // R7
  AST_RESET_PASS: assert property (@(posedge clk_i)
    !rst_ni |-> pass_o);  // R8
endmodule

// File: rtl/prbs7_bist.sv
module prbs7_bist
  import prbs7_pkg::*;
#(
  parameter int unsigned SEED_WORDS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              latch_i,
  input  logic [WORD_W-1:0] tx_data_i,
  input  logic [WORD_W-1:0] rx_data_i,
  output logic [WORD_W-1:0] tx_word_o,
  output logic              pass_o
);
  prbs7_gen u_gen (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .tx_data_i (tx_data_i),
    .tx_word_o (tx_word_o)
  );

  prbs7_chk #(.SEED_WORDS(SEED_WORDS)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .latch_i   (latch_i),
    .rx_data_i (rx_data_i),
    .pass_o    (pass_o)
  );
endmodule

// File: tb/prbs7_bist_tb_top.sv
module prbs7_bist_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic latch = 1'b0;
  logic [9:0] tx_data = 10'h155;
  logic [9:0] flip = '0;
  logic [9:0] tx_w, rx_w;
  logic pass;
  int checks = 0;
  int errors = 0;
  logic [6:0] m;
  logic [9:0] first_word;

  always #2 clk = ~clk;

  assign rx_w = tx_w ^ flip;

  prbs7_bist dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .latch_i(latch),
    .tx_data_i(tx_data), .rx_data_i(rx_w), .tx_word_o(tx_w), .pass_o(pass)
  );

  // entry = {req code, latch, flip mask, expected pass}; codes 0:R4 1:R5 2:R6
  localparam int N = 11;
  localparam logic [13:0] TBL [N] = '{
    {2'd0, 1'b0, 10'h3FF, 1'b1},
    {2'd0, 1'b0, 10'h000, 1'b1},
    {2'd1, 1'b0, 10'h000, 1'b1},
    {2'd1, 1'b0, 10'h001, 1'b0},
    {2'd1, 1'b0, 10'h000, 1'b1},
    {2'd1, 1'b0, 10'h200, 1'b0},
    {2'd1, 1'b0, 10'h000, 1'b1},
    {2'd2, 1'b1, 10'h000, 1'b1},
    {2'd2, 1'b1, 10'h010, 1'b0},
    {2'd2, 1'b1, 10'h000, 1'b0},
    {2'd2, 1'b1, 10'h000, 1'b0}
  };

  function automatic logic [9:0] mword(input logic [6:0] s);
    logic [6:0] t = s;
    logic [9:0] w;
    for (int i = 0; i < 10; i++) begin
      w[i] = t[6];
      t = {t[5:0], t[6] ^ t[5]};
    end
    return w;
  endfunction

  function automatic logic [6:0] mnext(input logic [6:0] s);
    logic [6:0] t = s;
    for (int i = 0; i < 10; i++) t = {t[5:0], t[6] ^ t[5]};
    return t;
  endfunction

  task automatic chk(input string tag, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    string tag;
    repeat (3) @(negedge clk);
    chk("R8 pass in reset", {9'b0, pass}, 10'h001);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 pass after reset", {9'b0, pass}, 10'h001);
    chk("R3 bypass word", tx_w, 10'h155);

    // table walk, loopback with XOR corruption
    en = 1'b1;
    m = 7'h7F;
    first_word = mword(7'h7F);
    for (int k = 0; k < N; k++) begin
      latch   = TBL[k][11];
      flip    = TBL[k][10:1];
      tx_data = 10'(k * 37 + 5);
      #0;
      chk("R2 generated word", tx_w, mword(m));
      @(posedge clk);
      m = mnext(m);
      @(negedge clk);
      case (TBL[k][13:12])
        2'd0: tag = "R4 seeding";
        2'd1: tag = "R5 live";
        default: tag = "R6 latched";
      endcase
      chk(tag, {9'b0, pass}, {9'b0, TBL[k][0]});
    end

    flip = '0;
    repeat (5) @(negedge clk);
    chk("R6 sticky holds", {9'b0, pass}, 10'h000);

    // stop test
    en = 1'b0;
    tx_data = 10'h2A7;
    #0;
    chk("R3 bypass while off", tx_w, 10'h2A7);
    @(negedge clk);
    chk("R7 cleared by disable", {9'b0, pass}, 10'h001);

    // restart, full period loopback in latched mode
    en = 1'b1;
    latch = 1'b1;
    m = 7'h7F;
    #0;
    chk("R3 restart from seed", tx_w, first_word);
    for (int k = 0; k < 127; k++) begin
      @(posedge clk);
      m = mnext(m);
      @(negedge clk);
    end
    chk("R1 model back at seed", {3'b0, m}, 10'h07F);
    chk("R1 period of 127 words", tx_w, first_word);
    chk("R6 clean loop stays passing", {9'b0, pass}, 10'h001);

    // single error after long run in latched mode
    flip = 10'h100;
    @(negedge clk);
    flip = '0;
    chk("R6 late error", {9'b0, pass}, 10'h000);
    repeat (3) @(negedge clk);
    chk("R6 late error holds", {9'b0, pass}, 10'h000);

    // reset mid test
    rst_n = 1'b0;
    @(negedge clk);
    chk("R8 reset clears fail", {9'b0, pass}, 10'h001);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule